// File: doc/BRIEF.md
# Boot ROM Select and Bus Width Steering

This block sits between a small embedded CPU and its external bus. It produces the chip select for the boot ROM and decides, on every memory and I/O cycle, whether the transfer is one byte or one word wide. It also steers the returned bytes onto the CPU read lanes. The two width inputs from the bus, one for memory and one for I/O, are merged inside the block into a single active-low width request. That merged request governs memory cycles, external I/O cycles and cycles to the block's own configuration ports alike.

The ROM window is the top 64 KB of the 24-bit address space. After reset, the ROM select is qualified by the memory read and write strobes. In that state the select, and so a width request wired to it, is not valid until a strobe asserts, and early fetches run byte-wide. A byte-wide read of a word-wide ROM returns the same byte at even and odd addresses. Boot code can be written around this. It then sets one configuration bit so that the select becomes a plain address decode, valid as soon as the address is stable.

Configuration uses an index/data port pair in I/O space at 22h and 23h. A single word write to 22h carries the index in its low byte and the data in its high byte.

Top module: `romsel_bus_sizer`

## Requirements
- R1: After reset the index register and the control register at index B3h are both 00h, so ROM select is strobe-qualified; reading port 22h or 23h returns 0000h.
- R2: The ROM select `rom_cs_n` stays high whenever address bits 23:16 are not all ones, whatever the strobes and configuration.
- R3: While bit 2 of the control register at index B3h is 0, `rom_cs_n` is low for a window address only while `mem_rd_n` or `mem_wr_n` is low.
- R4: While bit 2 of the control register at index B3h is 1, `rom_cs_n` is low for every window address, even with both memory strobes high.
- R5: A word I/O write (`cpu_word`=1) to port 22h loads the index from data bits 7:0 and writes data bits 15:8 to that index in the same cycle; writing 04B3h sets index B3h to 04h.
- R6: A byte I/O write to port 22h loads the index from bits 7:0; any write to port 23h stores bits 7:0 at the current index. An I/O read of 22h returns {00h, index}, and an I/O read of 23h returns {00h, data at the index}.
- R7: Only index B3h holds data; writes to any other index change nothing, and reads of any other index return 00h.
- R8: `cycle_wide` is 1 when either `msize16_n` or `iosize16_n` is low, and 0 only when both are high.
- R9: On a read not aimed at the configuration ports with the width request active, an even address returns the bus word unchanged, and an odd address returns bus bits 15:8 on both byte lanes.
- R10: On such a read with the width request inactive, bus bits 7:0 appear on both byte lanes, so even and odd addresses return the same byte.
- R11: `cpu_rdata` is 0000h whenever neither `mem_rd_n` nor `io_rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 24 | CPU address; bits 15:0 serve as the I/O port number |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| cpu_word | input | 1 | CPU requests a word transfer |
| cpu_wdata | input | 16 | CPU write data |
| msize16_n | input | 1 | Memory word-width request, active low |
| iosize16_n | input | 1 | I/O word-width request, active low |
| bus_rdata | input | 16 | Read data from the external bus |
| rom_cs_n | output | 1 | Boot ROM chip select, active low |
| cycle_wide | output | 1 | Current cycle runs word-wide |
| cpu_rdata | output | 16 | Steered read data to the CPU |

## Verification
The ROM select is driven with addresses inside, just below and far outside the window. Each address is tried with no strobe, with the read strobe and with the write strobe, both before and after the decode bit is set, so that gating and decode can be told apart. Steering is fed the bus word 5AA5h at even and odd addresses, under each width input alone and under neither. These cases separate the word-wide, high-byte-duplicating and low-byte-duplicating paths. Configuration is exercised with byte and word writes to both implemented and unimplemented indexes. Each is read back through the ports, which shows whether the index and data were taken from the right byte.

// File: rtl/romsel_pkg.sv
package romsel_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] index;
        logic [BYTE_W-1:0] ctrl;
    } cfg_state_t;
endpackage

// File: rtl/romsel_cfg_regs.sv
module romsel_cfg_regs
    import romsel_pkg::*;
#(
    parameter int             IO_ADDR_W = 16,
    parameter logic [15:0]    CFG_PORT  = 16'h0022,
    parameter logic [7:0]     CTRL_IDX  = 8'hB3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic                 word,
    input  logic [15:0]          wdata,
    output logic [BYTE_W-1:0]    ctrl,
    output logic                 cfg_hit,
    output logic [BYTE_W-1:0]    cfg_rdata
);
    localparam logic [IO_ADDR_W-1:0] IDX_PORT = IO_ADDR_W'(CFG_PORT);
    localparam logic [IO_ADDR_W-1:0] DAT_PORT = IO_ADDR_W'(CFG_PORT + 16'd1);

    cfg_state_t st_d, st_q;
    logic       at_idx, at_dat;

    assign at_idx = (io_addr == IDX_PORT);
    assign at_dat = (io_addr == DAT_PORT);

    always_comb begin
        st_d = st_q;
        if (io_wr && at_idx) begin
            st_d.index = wdata[7:0];
            if (word && (wdata[7:0] == CTRL_IDX)) begin
                st_d.ctrl = wdata[15:8];
            end
        end else if (io_wr && at_dat) begin
            if (st_q.index == CTRL_IDX) begin
                st_d.ctrl = wdata[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl    = st_q.ctrl;
    assign cfg_hit = io_rd && (at_idx || at_dat);

    always_comb begin
        cfg_rdata = '0;
        if (at_idx) begin
            cfg_rdata = st_q.index;
        end else if (at_dat && (st_q.index == CTRL_IDX)) begin
            cfg_rdata = st_q.ctrl;
        end
    end

    // R5: word write to the index port loads the index from the low byte
    a_r5_word_index: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_idx && word) |=> (st_q.index == $past(wdata[7:0])));

    // R6: byte write to the index port loads the index
    a_r6_byte_index: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_idx && !word) |=> (st_q.index == $past(wdata[7:0])));

    // R7: a data write aimed at an unimplemented index leaves the control byte alone
    a_r7_unimpl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_dat && (st_q.index != CTRL_IDX)) |=> $stable(st_q.ctrl));
endmodule

// File: rtl/romsel_decode.sv
module romsel_decode #(
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HI_W-1:0] addr_hi,
    input  logic            mem_rd_n,
    input  logic            mem_wr_n,
    input  logic            decode_only,
    output logic            rom_cs_n
);
    logic in_win;
    logic strobe;

    assign in_win = (addr_hi == '1);
    assign strobe = !mem_rd_n || !mem_wr_n;

    always_comb begin
        rom_cs_n = 1'b1;
        if (in_win && (decode_only || strobe)) begin
            rom_cs_n = 1'b0;
        end
    end

    // R2: no select outside the window
    a_r2_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hi != '1) |-> rom_cs_n);

    // R3: gated mode needs a memory strobe
    a_r3_gated_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!decode_only && mem_rd_n && mem_wr_n) |-> rom_cs_n);
endmodule

// File: rtl/romsel_steer.sv
module romsel_steer
    import romsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_active,
    input  logic              wide,
    input  logic              odd,
    input  logic              cfg_hit,
    input  logic [BYTE_W-1:0] cfg_rdata,
    input  logic [15:0]       bus_rdata,
    output logic [15:0]       cpu_rdata
);
    logic [BYTE_W-1:0] lo_b, hi_b;

    assign lo_b = bus_rdata[7:0];
    assign hi_b = bus_rdata[15:8];

    always_comb begin
        cpu_rdata = '0;
        if (rd_active) begin
            if (cfg_hit) begin
                cpu_rdata = {8'h00, cfg_rdata};
            end else if (wide) begin
                cpu_rdata = odd ? {hi_b, hi_b} : bus_rdata;
            end else begin
                cpu_rdata = {lo_b, lo_b};
            end
        end
    end

    // R10: byte-wide reads present one byte on both lanes
    a_r10_narrow_dup: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && !cfg_hit && !wide) |-> (cpu_rdata[15:8] == cpu_rdata[7:0]));

    // R11: nothing is returned without a read strobe
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |-> (cpu_rdata == 16'h0000));
endmodule

// File: rtl/romsel_bus_sizer.sv
module romsel_bus_sizer
    import romsel_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          WIN_LOG2  = 16,
    parameter int          IO_ADDR_W = 16,
    parameter logic [15:0] CFG_PORT  = 16'h0022,
    parameter logic [7:0]  CTRL_IDX  = 8'hB3,
    parameter int          DEC_BIT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_rd_n,
    input  logic              mem_wr_n,
    input  logic              io_rd_n,
    input  logic              io_wr_n,
    input  logic              cpu_word,
    input  logic [15:0]       cpu_wdata,
    input  logic              msize16_n,
    input  logic              iosize16_n,
    input  logic [15:0]       bus_rdata,
    output logic              rom_cs_n,
    output logic              cycle_wide,
    output logic [15:0]       cpu_rdata
);
    localparam int HI_W = ADDR_W - WIN_LOG2;

    logic [BYTE_W-1:0] ctrl;
    logic              cfg_hit;
    logic [BYTE_W-1:0] cfg_rdata;

    assign cycle_wide = !(msize16_n && iosize16_n);

    romsel_cfg_regs #(
        .IO_ADDR_W (IO_ADDR_W),
        .CFG_PORT  (CFG_PORT),
        .CTRL_IDX  (CTRL_IDX)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (addr[IO_ADDR_W-1:0]),
        .io_rd     (!io_rd_n),
        .io_wr     (!io_wr_n),
        .word      (cpu_word),
        .wdata     (cpu_wdata),
        .ctrl      (ctrl),
        .cfg_hit   (cfg_hit),
        .cfg_rdata (cfg_rdata)
    );

    romsel_decode #(
        .HI_W (HI_W)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_hi     (addr[ADDR_W-1:WIN_LOG2]),
        .mem_rd_n    (mem_rd_n),
        .mem_wr_n    (mem_wr_n),
        .decode_only (ctrl[DEC_BIT]),
        .rom_cs_n    (rom_cs_n)
    );

    romsel_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_active (!mem_rd_n || !io_rd_n),
        .wide      (cycle_wide),
        .odd       (addr[0]),
        .cfg_hit   (cfg_hit),
        .cfg_rdata (cfg_rdata),
        .bus_rdata (bus_rdata),
        .cpu_rdata (cpu_rdata)
    );

    // R4: decode mode selects the window without any strobe
    a_r4_decode_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[DEC_BIT] && (addr[ADDR_W-1:WIN_LOG2] == '1)) |-> !rom_cs_n);
endmodule

// File: tb/tb_romsel_bus_sizer.sv
`timescale 1ns/1ps
module tb_romsel_bus_sizer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] addr;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, cpu_word;
    logic [15:0] cpu_wdata, bus_rdata;
    logic        msize16_n, iosize16_n;
    logic        rom_cs_n, cycle_wide;
    logic [15:0] cpu_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    romsel_bus_sizer dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .cpu_word(cpu_word), .cpu_wdata(cpu_wdata),
        .msize16_n(msize16_n), .iosize16_n(iosize16_n),
        .bus_rdata(bus_rdata), .rom_cs_n(rom_cs_n),
        .cycle_wide(cycle_wide), .cpu_rdata(cpu_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        mem_rd_n = 1'b1; mem_wr_n = 1'b1; io_rd_n = 1'b1; io_wr_n = 1'b1;
        cpu_word = 1'b0; cpu_wdata = '0;
    endtask

    task automatic io_write(input logic [15:0] port, input logic [15:0] d, input logic w);
        @(negedge clk);
        addr = {8'h00, port}; cpu_wdata = d; cpu_word = w; io_wr_n = 1'b0;
        @(negedge clk);
        idle();
    endtask

    task automatic io_read_check(input string tag, input logic [15:0] port, input logic [15:0] exp);
        @(negedge clk);
        addr = {8'h00, port}; io_rd_n = 1'b0;
        #1;
        check(tag, cpu_rdata, exp);
        @(negedge clk);
        idle();
    endtask

    task automatic cs_check(input string tag, input logic [23:0] a, input logic rd_n,
                            input logic wr_n, input logic exp);
        @(negedge clk);
        addr = a; mem_rd_n = rd_n; mem_wr_n = wr_n;
        #1;
        check(tag, {15'd0, rom_cs_n}, {15'd0, exp});
        @(negedge clk);
        idle();
    endtask

    task automatic mem_read_check(input string tag, input logic [23:0] a, input logic ms_n,
                                  input logic ios_n, input logic [15:0] exp);
        @(negedge clk);
        addr = a; msize16_n = ms_n; iosize16_n = ios_n; bus_rdata = 16'h5AA5; mem_rd_n = 1'b0;
        #1;
        check(tag, cpu_rdata, exp);
        @(negedge clk);
        idle(); msize16_n = 1'b1; iosize16_n = 1'b1;
    endtask

    task automatic t_reset();
        cs_check("R1 gated after reset", 24'hFFFFF0, 1'b1, 1'b1, 1'b1);
        io_read_check("R1 index reset", 16'h0022, 16'h0000);
        io_read_check("R1 data reset", 16'h0023, 16'h0000);
    endtask

    task automatic t_gated();
        cs_check("R3 read strobe selects", 24'hFFFFF0, 1'b0, 1'b1, 1'b0);
        cs_check("R3 write strobe selects", 24'hFF0000, 1'b1, 1'b0, 1'b0);
        cs_check("R3 no strobe no select", 24'hFF8000, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_outside();
        cs_check("R2 just below window", 24'hFEFFFF, 1'b0, 1'b1, 1'b1);
        cs_check("R2 low address", 24'h000000, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_width();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            msize16_n = i[0]; iosize16_n = i[1];
            #1;
            check("R8 combined width", {15'd0, cycle_wide}, {15'd0, !(i[0] && i[1])});
        end
        @(negedge clk);
        msize16_n = 1'b1; iosize16_n = 1'b1;
    endtask

    task automatic t_steer();
        mem_read_check("R10 narrow even", 24'hFFFFF0, 1'b1, 1'b1, 16'hA5A5);
        mem_read_check("R10 narrow odd", 24'hFFFFF1, 1'b1, 1'b1, 16'hA5A5);
        mem_read_check("R9 wide even", 24'hFFFFF0, 1'b0, 1'b1, 16'h5AA5);
        mem_read_check("R9 wide odd", 24'hFFFFF1, 1'b0, 1'b1, 16'h5A5A);
        mem_read_check("R9 io-size alone widens", 24'h001000, 1'b1, 1'b0, 16'h5AA5);
    endtask

    task automatic t_idle();
        @(negedge clk);
        addr = 24'hFFFFF0; bus_rdata = 16'h1234; msize16_n = 1'b0;
        #1;
        check("R11 idle output zero", cpu_rdata, 16'h0000);
        @(negedge clk);
        msize16_n = 1'b1;
    endtask

    task automatic t_byte_cfg();
        io_write(16'h0022, 16'h00B3, 1'b0);
        io_read_check("R6 index readback", 16'h0022, 16'h00B3);
        io_write(16'h0023, 16'h0011, 1'b0);
        io_read_check("R6 data readback", 16'h0023, 16'h0011);
        cs_check("R3 bit2 clear stays gated", 24'hFFFFF0, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_unimpl();
        io_write(16'h0022, 16'h0070, 1'b0);
        io_write(16'h0023, 16'h00FF, 1'b0);
        io_read_check("R7 unimplemented reads zero", 16'h0023, 16'h0000);
        io_write(16'h0022, 16'h00B3, 1'b0);
        io_read_check("R7 control untouched", 16'h0023, 16'h0011);
    endtask

    task automatic t_word_cfg();
        io_write(16'h0022, 16'h04B3, 1'b1);
        io_read_check("R5 word index", 16'h0022, 16'h00B3);
        io_read_check("R5 word data", 16'h0023, 16'h0004);
        cs_check("R4 decode mode no strobe", 24'hFFFFF0, 1'b1, 1'b1, 1'b0);
        cs_check("R2 decode mode outside", 24'h7FFFF0, 1'b1, 1'b1, 1'b1);
        io_write(16'h0022, 16'hFF70, 1'b1);
        io_read_check("R5 word index other", 16'h0022, 16'h0070);
        io_write(16'h0022, 16'h00B3, 1'b0);
        io_read_check("R7 word write elsewhere ignored", 16'h0023, 16'h0004);
        io_write(16'h0023, 16'h0000, 1'b0);
        cs_check("R3 gating restored", 24'hFFFFF0, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; bus_rdata = '0;
        msize16_n = 1'b1; iosize16_n = 1'b1;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gated();
        t_outside();
        t_width();
        t_steer();
        t_idle();
        t_byte_cfg();
        t_unimpl();
        t_word_cfg();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule